// File: doc/BRIEF.md
# Trap Entry and Delegation Unit

This unit performs every state update a hart needs when it takes a trap. The core presents a one-cycle trap strobe along with the cause number, a flag that marks an interrupt, the faulting address and the PC of the trapping instruction. On the same clock edge the unit picks a target level, supervisor or machine. It then loads the next PC from that level's vector base, saves the old PC, the cause and (for address faults) the bad address, and moves the interrupt-enable stack. Finally it switches the privilege.

The unit owns both delegation masks, both vector bases, the saved PC, cause and bad-address registers for each level, the status enable and previous-state fields, and the current privilege. A select-coded register port loads and reads all of them. Environment-call causes are renamed to match the privilege the call came from. The renamed code is then used both for the delegation lookup and for the recorded cause.

Top module: `trap_entry_unit`

## Requirements
- R1: After reset the privilege is machine (code 3), `pcLoad` is low and every register readable through the port reads zero.
- R2: Register port select codes: 0 exception delegation, 1 interrupt delegation, 2 supervisor vector, 3 machine vector, 4 supervisor saved PC, 5 supervisor cause, 6 supervisor bad address, 7 machine saved PC, 8 machine cause, 9 machine bad address, 10 status, 11 privilege. Vector bases store the written value with bits 1:0 forced to zero.
- R3: Only the low `NUM_DELEG` (16) bits of each delegation mask are held. Higher bits read as zero whatever is written.
- R4: A trap goes to supervisor only when the privilege is user (0) or supervisor (1) and the delegation bit indexed by the cause number is set. Interrupts use the interrupt mask and exceptions use the exception mask. Every other trap goes to machine (3), including every trap taken from machine.
- R5: On a supervisor trap, `pcLoad` is high in the following cycle with `pcTarget` equal to the supervisor vector. The supervisor saved PC takes `curPc` and supervisor previous-enable (status bit 5) takes supervisor enable (bit 1). Supervisor previous-privilege (bit 8) takes bit 0 of the old privilege, bit 1 is cleared and the privilege becomes 1. Machine registers are unchanged.
- R6: On a machine trap, `pcTarget` is the machine vector and the machine saved PC takes `curPc`. Machine previous-enable (bit 7) takes machine enable (bit 3), and machine previous-privilege (bits 12:11) takes the old privilege. Bit 3 is cleared and the privilege becomes 3. Supervisor registers are unchanged.
- R7: An interrupt records its cause number with bit 31 set. An exception records its cause number with bit 31 clear.
- R8: An exception raised with any environment-call code (8 to 11) is recorded and delegated as 8 plus the privilege it came from: 8 from user, 9 from supervisor, 11 from machine.
- R9: The target level's bad-address register takes `trapAddr` only for exception causes 0, 1, 4, 5, 6, 7, 12, 13 and 15. For any other trap it keeps its value.
- R10: When a register write and a trap fall in the same cycle, the write is dropped and the trap updates take effect.
- R11: `pcLoad` is high only in the cycle after a trap strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| trapValid | input | 1 | One-cycle trap strobe |
| trapIsIrq | input | 1 | The trap is an interrupt |
| trapCause | input | CAUSE_W | Raised cause number |
| trapAddr | input | XLEN | Faulting address |
| curPc | input | XLEN | PC of the trapping instruction |
| csrWe | input | 1 | Register write enable |
| csrSel | input | 4 | Register select code |
| csrWdata | input | XLEN | Register write data |
| csrRdata | output | XLEN | Selected register value (combinational) |
| pcLoad | output | 1 | Redirect strobe, high the cycle after a trap |
| pcTarget | output | XLEN | Redirect PC |
| privOut | output | 2 | Current privilege |

## Verification
A trap strobe and a register write can land on the same clock edge, and both try to change the same registers. The bench provokes this by pulsing `trapValid` while `csrWe` targets the machine saved PC with an unrelated pattern. It then reads that register back: the trapping PC must be present, and the written pattern must not be. The table walk exercises the delegation decision against both masks from all three privileges, using the environment-call renaming and interrupt causes whose numbers collide with delegated exception bits.

// File: rtl/trap_pkg.sv
package trap_pkg;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  localparam logic [3:0] SEL_EDELEG = 4'd0;
  localparam logic [3:0] SEL_IDELEG = 4'd1;
  localparam logic [3:0] SEL_STVEC  = 4'd2;
  localparam logic [3:0] SEL_MTVEC  = 4'd3;
  localparam logic [3:0] SEL_SEPC   = 4'd4;
  localparam logic [3:0] SEL_SCAUSE = 4'd5;
  localparam logic [3:0] SEL_SBAD   = 4'd6;
  localparam logic [3:0] SEL_MEPC   = 4'd7;
  localparam logic [3:0] SEL_MCAUSE = 4'd8;
  localparam logic [3:0] SEL_MBAD   = 4'd9;
  localparam logic [3:0] SEL_STATUS = 4'd10;
  localparam logic [3:0] SEL_PRIV   = 4'd11;

  // Status register bit positions
  localparam int ST_SIE  = 1;
  localparam int ST_MIE  = 3;
  localparam int ST_SPIE = 5;
  localparam int ST_MPIE = 7;
  localparam int ST_SPP  = 8;
  localparam int ST_MPP  = 11;

  typedef struct packed {
    logic       sie;
    logic       mie;
    logic       spie;
    logic       mpie;
    logic       spp;
    logic [1:0] mpp;
  } status_t;

  // Control-to-datapath strobes
  typedef struct packed {
    logic toSup;
    logic toMach;
    logic badWr;
  } strobe_t;

endpackage

// File: rtl/trap_ctrl.sv
module trap_ctrl
  import trap_pkg::*;
#(
  parameter int NUM_DELEG = 16,
  parameter int CAUSE_W   = 5
) (
  input  logic                 trapValid,
  input  logic                 trapIsIrq,
  input  logic [CAUSE_W-1:0]   trapCause,
  input  logic [1:0]           privQ,
  input  logic [NUM_DELEG-1:0] edelegQ,
  input  logic [NUM_DELEG-1:0] idelegQ,
  output strobe_t              strobes,
  output logic [CAUSE_W-1:0]   causeFixed
);

  localparam int PAD_W = 1 << CAUSE_W;

  logic             isEcall;
  logic [PAD_W-1:0] delegPad;
  logic             delegBit;
  logic             lowPriv;

  function automatic logic isAddrFault(input logic [CAUSE_W-1:0] c);
    case (c)
      CAUSE_W'(0), CAUSE_W'(1), CAUSE_W'(4), CAUSE_W'(5), CAUSE_W'(6),
      CAUSE_W'(7), CAUSE_W'(12), CAUSE_W'(13), CAUSE_W'(15): return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  always_comb begin
    isEcall = !trapIsIrq && (trapCause >= CAUSE_W'(8)) && (trapCause <= CAUSE_W'(11));
    causeFixed = isEcall ? (CAUSE_W'(8) + CAUSE_W'(privQ)) : trapCause;
  end

  always_comb begin
    delegPad = trapIsIrq ? PAD_W'(idelegQ) : PAD_W'(edelegQ);
    delegBit = delegPad[causeFixed];
    lowPriv  = (privQ == PRIV_U) || (privQ == PRIV_S);
  end

  always_comb begin
    strobes.toSup  = trapValid && lowPriv && delegBit;
    strobes.toMach = trapValid && !(lowPriv && delegBit);
    strobes.badWr  = trapValid && !trapIsIrq && isAddrFault(causeFixed);
  end

endmodule

// File: rtl/trap_dpath.sv
module trap_dpath
  import trap_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int NUM_DELEG = 16,
  parameter int CAUSE_W   = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strobes,
  input  logic [CAUSE_W-1:0]   causeFixed,
  input  logic                 trapIsIrq,
  input  logic [XLEN-1:0]      trapAddr,
  input  logic [XLEN-1:0]      curPc,
  input  logic                 csrWe,
  input  logic [3:0]           csrSel,
  input  logic [XLEN-1:0]      csrWdata,
  output logic [XLEN-1:0]      csrRdata,
  output logic                 pcLoad,
  output logic [XLEN-1:0]      pcTarget,
  output logic [1:0]           privOut,
  output status_t              statusOut,
  output logic [NUM_DELEG-1:0] edelegOut,
  output logic [NUM_DELEG-1:0] idelegOut
);

  localparam int ZPAD = XLEN - 1 - CAUSE_W;

  logic [NUM_DELEG-1:0] edelegQ, idelegQ;
  logic [XLEN-1:0]      stvecQ, mtvecQ;
  logic [XLEN-1:0]      sepcQ, scauseQ, sbadQ;
  logic [XLEN-1:0]      mepcQ, mcauseQ, mbadQ;
  status_t              statusQ;
  logic [1:0]           privQ;
  logic [XLEN-1:0]      causeVal;
  logic [XLEN-1:0]      statusWord;
  logic [XLEN-1:0]      tvecMasked;

  assign causeVal   = {trapIsIrq, {ZPAD{1'b0}}, causeFixed};
  assign tvecMasked = {csrWdata[XLEN-1:2], 2'b00};

  always_comb begin
    statusWord = '0;
    statusWord[ST_SIE]          = statusQ.sie;
    statusWord[ST_MIE]          = statusQ.mie;
    statusWord[ST_SPIE]         = statusQ.spie;
    statusWord[ST_MPIE]         = statusQ.mpie;
    statusWord[ST_SPP]          = statusQ.spp;
    statusWord[ST_MPP+1:ST_MPP] = statusQ.mpp;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      edelegQ  <= '0;
      idelegQ  <= '0;
      stvecQ   <= '0;
      mtvecQ   <= '0;
      sepcQ    <= '0;
      scauseQ  <= '0;
      sbadQ    <= '0;
      mepcQ    <= '0;
      mcauseQ  <= '0;
      mbadQ    <= '0;
      statusQ  <= '0;
      privQ    <= PRIV_M;
      pcLoad   <= 1'b0;
      pcTarget <= '0;
    end else begin
      pcLoad <= strobes.toSup || strobes.toMach;
      if (strobes.toSup) begin
        pcTarget     <= stvecQ;
        sepcQ        <= curPc;
        scauseQ      <= causeVal;
        if (strobes.badWr) sbadQ <= trapAddr;
        statusQ.spie <= statusQ.sie;
        statusQ.spp  <= privQ[0];
        statusQ.sie  <= 1'b0;
        privQ        <= PRIV_S;
      end else if (strobes.toMach) begin
        pcTarget     <= mtvecQ;
        mepcQ        <= curPc;
        mcauseQ      <= causeVal;
        if (strobes.badWr) mbadQ <= trapAddr;
        statusQ.mpie <= statusQ.mie;
        statusQ.mpp  <= privQ;
        statusQ.mie  <= 1'b0;
        privQ        <= PRIV_M;
      end else if (csrWe) begin
        case (csrSel)
          SEL_EDELEG: edelegQ <= csrWdata[NUM_DELEG-1:0];
          SEL_IDELEG: idelegQ <= csrWdata[NUM_DELEG-1:0];
          SEL_STVEC:  stvecQ  <= tvecMasked;
          SEL_MTVEC:  mtvecQ  <= tvecMasked;
          SEL_SEPC:   sepcQ   <= csrWdata;
          SEL_SCAUSE: scauseQ <= csrWdata;
          SEL_SBAD:   sbadQ   <= csrWdata;
          SEL_MEPC:   mepcQ   <= csrWdata;
          SEL_MCAUSE: mcauseQ <= csrWdata;
          SEL_MBAD:   mbadQ   <= csrWdata;
          SEL_STATUS: begin
            statusQ.sie  <= csrWdata[ST_SIE];
            statusQ.mie  <= csrWdata[ST_MIE];
            statusQ.spie <= csrWdata[ST_SPIE];
            statusQ.mpie <= csrWdata[ST_MPIE];
            statusQ.spp  <= csrWdata[ST_SPP];
            statusQ.mpp  <= csrWdata[ST_MPP+1:ST_MPP];
          end
          SEL_PRIV:   privQ   <= csrWdata[1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (csrSel)
      SEL_EDELEG: csrRdata = XLEN'(edelegQ);
      SEL_IDELEG: csrRdata = XLEN'(idelegQ);
      SEL_STVEC:  csrRdata = stvecQ;
      SEL_MTVEC:  csrRdata = mtvecQ;
      SEL_SEPC:   csrRdata = sepcQ;
      SEL_SCAUSE: csrRdata = scauseQ;
      SEL_SBAD:   csrRdata = sbadQ;
      SEL_MEPC:   csrRdata = mepcQ;
      SEL_MCAUSE: csrRdata = mcauseQ;
      SEL_MBAD:   csrRdata = mbadQ;
      SEL_STATUS: csrRdata = statusWord;
      SEL_PRIV:   csrRdata = XLEN'(privQ);
      default:    csrRdata = '0;
    endcase
  end

  assign privOut   = privQ;
  assign statusOut = statusQ;
  assign edelegOut = edelegQ;
  assign idelegOut = idelegQ;

endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
  import trap_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int NUM_DELEG = 16,
  parameter int CAUSE_W   = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               trapValid,
  input  logic               trapIsIrq,
  input  logic [CAUSE_W-1:0] trapCause,
  input  logic [XLEN-1:0]    trapAddr,
  input  logic [XLEN-1:0]    curPc,
  input  logic               csrWe,
  input  logic [3:0]         csrSel,
  input  logic [XLEN-1:0]    csrWdata,
  output logic [XLEN-1:0]    csrRdata,
  output logic               pcLoad,
  output logic [XLEN-1:0]    pcTarget,
  output logic [1:0]         privOut
);

  strobe_t              strobes;
  logic [CAUSE_W-1:0]   causeFixed;
  status_t              statusQ;
  logic [NUM_DELEG-1:0] edelegQ, idelegQ;

  trap_ctrl #(.NUM_DELEG(NUM_DELEG), .CAUSE_W(CAUSE_W)) uCtrl (
    .trapValid (trapValid),
    .trapIsIrq (trapIsIrq),
    .trapCause (trapCause),
    .privQ     (privOut),
    .edelegQ   (edelegQ),
    .idelegQ   (idelegQ),
    .strobes   (strobes),
    .causeFixed(causeFixed)
  );

  trap_dpath #(.XLEN(XLEN), .NUM_DELEG(NUM_DELEG), .CAUSE_W(CAUSE_W)) uDpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .causeFixed(causeFixed),
    .trapIsIrq (trapIsIrq),
    .trapAddr  (trapAddr),
    .curPc     (curPc),
    .csrWe     (csrWe),
    .csrSel    (csrSel),
    .csrWdata  (csrWdata),
    .csrRdata  (csrRdata),
    .pcLoad    (pcLoad),
    .pcTarget  (pcTarget),
    .privOut   (privOut),
    .statusOut (statusQ),
    .edelegOut (edelegQ),
    .idelegOut (idelegQ)
  );

endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk
  import trap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic            trapValid,
  input logic            csrWe,
  input logic [3:0]      csrSel,
  input logic            pcLoad,
  input logic [XLEN-1:0] pcTarget,
  input logic [1:0]      privOut,
  input status_t         statusQ
);

  AST_LOAD_AFTER_TRAP: assert property (@(posedge clk) disable iff (!rstN)
    trapValid |=> pcLoad); // R5

  AST_NO_SPURIOUS_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    !trapValid |=> !pcLoad); // R11

  AST_MACHINE_STAYS: assert property (@(posedge clk) disable iff (!rstN)
    (trapValid && privOut == PRIV_M) |=> privOut == PRIV_M); // R4

  AST_ENABLE_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    trapValid |=> (privOut == PRIV_M) ? !statusQ.mie : !statusQ.sie); // R6

  AST_TARGET_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    pcLoad |-> pcTarget[1:0] == 2'b00); // R2

  AST_PRIV_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!trapValid && !(csrWe && csrSel == SEL_PRIV)) |=> $stable(privOut)); // R10

  AST_TRAP_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    trapValid |=> (privOut == PRIV_S || privOut == PRIV_M)); // R4

endmodule

bind trap_entry_unit trap_entry_chk #(.XLEN(XLEN)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .trapValid(trapValid),
  .csrWe    (csrWe),
  .csrSel   (csrSel),
  .pcLoad   (pcLoad),
  .pcTarget (pcTarget),
  .privOut  (privOut),
  .statusQ  (statusQ)
);

// File: tb/sim_trap_entry_unit.sv
`timescale 1ns/1ps
module sim_trap_entry_unit;

  localparam int XLEN = 32;
  localparam int NV   = 14;
  localparam logic [31:0] STVEC_W = 32'h2000_0103;
  localparam logic [31:0] MTVEC_W = 32'h3000_0002;
  localparam logic [31:0] SENT    = 32'hDEAD_0000;
  localparam logic [31:0] EPCSENT = 32'hEEEE_0000;

  // {priv[1:0], irq, cause[4:0], toSup, expCause[31:0], badWr}
  localparam logic [41:0] VECS [NV] = '{
    {2'd0, 1'b0, 5'd0,  1'b1, 32'h0000_0000, 1'b1},
    {2'd0, 1'b0, 5'd2,  1'b0, 32'h0000_0002, 1'b0},
    {2'd1, 1'b0, 5'd13, 1'b1, 32'h0000_000D, 1'b1},
    {2'd3, 1'b0, 5'd13, 1'b0, 32'h0000_000D, 1'b1},
    {2'd0, 1'b0, 5'd11, 1'b1, 32'h0000_0008, 1'b0},
    {2'd1, 1'b0, 5'd8,  1'b0, 32'h0000_0009, 1'b0},
    {2'd3, 1'b0, 5'd8,  1'b0, 32'h0000_000B, 1'b0},
    {2'd0, 1'b1, 5'd5,  1'b1, 32'h8000_0005, 1'b0},
    {2'd1, 1'b1, 5'd7,  1'b0, 32'h8000_0007, 1'b0},
    {2'd3, 1'b1, 5'd1,  1'b0, 32'h8000_0001, 1'b0},
    {2'd0, 1'b0, 5'd15, 1'b0, 32'h0000_000F, 1'b1},
    {2'd1, 1'b0, 5'd3,  1'b0, 32'h0000_0003, 1'b0},
    {2'd0, 1'b1, 5'd13, 1'b0, 32'h8000_000D, 1'b0},
    {2'd1, 1'b0, 5'd1,  1'b1, 32'h0000_0001, 1'b1}
  };

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            trapValid = 1'b0;
  logic            trapIsIrq = 1'b0;
  logic [4:0]      trapCause = '0;
  logic [XLEN-1:0] trapAddr = '0;
  logic [XLEN-1:0] curPc = '0;
  logic            csrWe = 1'b0;
  logic [3:0]      csrSel = '0;
  logic [XLEN-1:0] csrWdata = '0;
  logic [XLEN-1:0] csrRdata;
  logic            pcLoad;
  logic [XLEN-1:0] pcTarget;
  logic [1:0]      privOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  trap_entry_unit u0 (
    .clk(clk), .rstN(rstN), .trapValid(trapValid), .trapIsIrq(trapIsIrq),
    .trapCause(trapCause), .trapAddr(trapAddr), .curPc(curPc),
    .csrWe(csrWe), .csrSel(csrSel), .csrWdata(csrWdata), .csrRdata(csrRdata),
    .pcLoad(pcLoad), .pcTarget(pcTarget), .privOut(privOut)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic csrWrite(input logic [3:0] sel, input logic [31:0] data);
    @(negedge clk);
    csrWe = 1'b1; csrSel = sel; csrWdata = data;
    @(negedge clk);
    csrWe = 1'b0;
  endtask

  task automatic csrRead(input logic [3:0] sel, output logic [31:0] data);
    csrSel = sel;
    #1;
    data = csrRdata;
  endtask

  task automatic fireTrap(input logic irq, input logic [4:0] cause,
                          input logic [31:0] addr, input logic [31:0] pc);
    @(negedge clk);
    trapValid = 1'b1; trapIsIrq = irq; trapCause = cause;
    trapAddr = addr; curPc = pc;
    @(negedge clk);
    trapValid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 priv", 32'(privOut), 32'd3);
    check("R1 pcLoad", 32'(pcLoad), 32'd0);
    for (int s = 0; s <= 10; s++) begin
      csrRead(4'(s), rd);
      check("R1 reg zero", rd, 32'd0);
    end

    // R2: vector bases drop low bits
    csrWrite(4'd2, STVEC_W);
    csrWrite(4'd3, MTVEC_W);
    csrRead(4'd2, rd); check("R2 stvec", rd, 32'h2000_0100);
    csrRead(4'd3, rd); check("R2 mtvec", rd, 32'h3000_0000);

    // R3: high delegation bits read zero
    csrWrite(4'd0, 32'hFFFF_FFFF);
    csrRead(4'd0, rd); check("R3 edeleg width", rd, 32'h0000_FFFF);
    csrWrite(4'd1, 32'hFFFF_0022);
    csrRead(4'd1, rd); check("R3 ideleg width", rd, 32'h0000_0022);
    csrWrite(4'd0, 32'h0000_3103);

    // Table walk: R4 R5 R6 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      logic [41:0] v;
      logic [1:0]  p;
      logic        sup;
      logic [31:0] pcv, av, expSt;
      v   = VECS[i];
      p   = v[41:40];
      sup = v[33];
      pcv = 32'h0000_1000 + 32'(i * 4);
      av  = 32'h0000_8000 + 32'(i);
      csrWrite(4'd6, SENT);
      csrWrite(4'd9, SENT);
      csrWrite(4'd4, EPCSENT);
      csrWrite(4'd7, EPCSENT);
      csrWrite(4'd10, 32'h0000_000A);
      csrWrite(4'd11, 32'(p));
      fireTrap(v[39], v[38:34], av, pcv);
      check("R11 pcLoad", 32'(pcLoad), 32'd1);
      check("R4 target pc", pcTarget, sup ? 32'h2000_0100 : 32'h3000_0000);
      check("R4 priv", 32'(privOut), sup ? 32'd1 : 32'd3);
      csrRead(sup ? 4'd5 : 4'd8, rd);
      check("R7 R8 cause", rd, v[32:1]);
      csrRead(sup ? 4'd4 : 4'd7, rd);
      check("R5 R6 saved pc", rd, pcv);
      csrRead(sup ? 4'd7 : 4'd4, rd);
      check("R5 R6 other level epc", rd, EPCSENT);
      csrRead(sup ? 4'd6 : 4'd9, rd);
      check("R9 bad address", rd, v[0] ? av : SENT);
      csrRead(sup ? 4'd9 : 4'd6, rd);
      check("R9 other bad address", rd, SENT);
      expSt = sup ? (32'h0000_0028 | (32'(p[0]) << 8))
                  : (32'h0000_0082 | (32'(p) << 11));
      csrRead(4'd10, rd);
      check(sup ? "R5 status" : "R6 status", rd, expSt);
      @(negedge clk);
      check("R11 pcLoad single", 32'(pcLoad), 32'd0);
    end

    // R10: write and trap in the same cycle
    csrWrite(4'd11, 32'd3);
    @(negedge clk);
    trapValid = 1'b1; trapIsIrq = 1'b0; trapCause = 5'd2;
    trapAddr = 32'h0; curPc = 32'h0000_ABC0;
    csrWe = 1'b1; csrSel = 4'd7; csrWdata = 32'h5555_5555;
    @(negedge clk);
    trapValid = 1'b0; csrWe = 1'b0;
    csrRead(4'd7, rd); check("R10 write dropped", rd, 32'h0000_ABC0);
    check("R10 pcLoad", 32'(pcLoad), 32'd1);

    // R8: ecall raised with a hypervisor code from supervisor
    csrWrite(4'd11, 32'd1);
    fireTrap(1'b0, 5'd10, 32'h0, 32'h0000_0200);
    csrRead(4'd8, rd); check("R8 ecall rename", rd, 32'd9);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule